// File: doc/BRIEF.md
# Stack delta engine

This block sits directly behind the instruction decoders and inspects every group of up to four micro-operations on its way to the back end. Operations whose only architectural effect is moving the stack pointer are absorbed. Pushes, calls, pops, returns and explicit stack adjustments are summed into a private 32-bit running delta by a small chain of dedicated adders, so the general ALUs never see them. The memory half of a push or call is still forwarded as a store, and the memory half of a pop or return as a load. Each of these carries the offset, relative to the last synchronised stack pointer, at which it must access memory.

When an operation names the stack pointer as an ordinary register operand, the engine first emits a synchronising add of the accumulated delta. It then clears the delta, so that the operation sees an exact register value. A group that holds more stack updates than there are adders, or more than one explicit stack-pointer user, is finished over several cycles. While that happens the decoders are held off with `in_ready`.

Top module: `stack_delta_engine`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1 and the running delta is zero, so a stack-relative memory operation is forwarded with offset 0.
- R2: A push (type 1) or call (type 3) lowers the delta by 4. It is forwarded as a store (kind 2) whose offset is the delta after the decrement.
- R3: A pop (type 2) or return (type 4) is forwarded as a load (kind 3) whose offset is the delta before the update. The delta then rises by 4.
- R4: A stack adjust (type 5) adds its immediate to the delta. Its output lane is cleared: valid, kind, immediate and offset are all 0.
- R5: A stack-relative memory operation (type 6) is forwarded as kind 4 with its immediate and the current delta as offset. The delta does not change.
- R6: Any other operation (type 0) is forwarded as kind 1 with its immediate and offset 0.
- R7: Lanes are handled in ascending order, and each lane observes the delta left by all earlier lanes in its group.
- R8: At most 3 stack updates (types 1 to 5) are absorbed per cycle. When a valid update would be the fourth, `in_ready` is 0 and that lane and all later lanes are handled in the next cycle, with the input held steady.
- R9: An explicit stack-pointer user (type 7) is forwarded as kind 5 with offset 0. If the delta just before it is non-zero, `out_sync_valid` is 1 in the same cycle, `out_sync_lane` gives its lane and `out_sync_amt` gives that delta. The delta is then zero. With a zero delta no sync is emitted, and the sync outputs read 0.
- R10: At most one explicit stack-pointer user is handled per cycle. A second one in a group is held to the next cycle, with `in_ready` 0.
- R11: The delta is 32 bits wide and all arithmetic on it wraps modulo 2^32.
- R12: A lane with `in_valid` 0 has no effect on the delta, and its output lane reads all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | LANES | Per-lane valid of the incoming group |
| in_type | input | LANES x 3 | Per-lane operation type code |
| in_imm | input | LANES x 32 | Per-lane immediate |
| in_ready | output | 1 | Group fully consumed at this edge; 0 means hold the group |
| out_valid | output | LANES | Per-lane valid of the forwarded group |
| out_kind | output | LANES x 3 | Forwarded operation kind (0 none, 1 pass, 2 store, 3 load, 4 stack memory, 5 explicit use) |
| out_imm | output | LANES x 32 | Forwarded immediate |
| out_ofs | output | LANES x 32 | Stack offset attached to the forwarded operation |
| out_sync_valid | output | 1 | A synchronising stack-pointer add is emitted |
| out_sync_lane | output | log2(LANES) | Lane that the sync add precedes |
| out_sync_amt | output | 32 | Amount of the sync add |

## Verification
The bench builds the block with its defaults: four lanes and three adders. At that size all 4096 combinations of the eight type codes across the four lanes can be swept, once with every lane valid and once under a rotating valid mask. The sweep therefore reaches every position of the fourth-update stall, of a second explicit user, of a sync taken with a zero or a non-zero delta, and of an update that follows a sync within one cycle. Directed groups add a wrap past zero and a long run of pushes. Every expected lane, sync and ready value comes from a running arithmetic model of the delta kept in the bench.

// File: rtl/stkeng_pkg.sv
package stkeng_pkg;

    localparam int DW = 32;
    localparam int TW = 3;

    typedef logic [DW-1:0] word_t;

    typedef enum logic [TW-1:0] {
        UT_OTHER = 3'd0,
        UT_PUSH  = 3'd1,
        UT_POP   = 3'd2,
        UT_CALL  = 3'd3,
        UT_RET   = 3'd4,
        UT_SPADJ = 3'd5,
        UT_SPMEM = 3'd6,
        UT_SPUSE = 3'd7
    } uop_type_e;

    typedef enum logic [TW-1:0] {
        OK_NONE  = 3'd0,
        OK_PASS  = 3'd1,
        OK_STORE = 3'd2,
        OK_LOAD  = 3'd3,
        OK_SPMEM = 3'd4,
        OK_SPUSE = 3'd5
    } out_kind_e;

    localparam word_t SLOT_BYTES = word_t'(4);

    typedef struct packed {
        logic      upd;
        logic      use_sp;
        out_kind_e kind;
        word_t     step;
    } class_t;

    function automatic class_t classify(uop_type_e t, word_t imm);
        class_t c;
        c = '{upd: 1'b0, use_sp: 1'b0, kind: OK_PASS, step: '0};
        unique case (t)
            UT_PUSH, UT_CALL: begin c.upd = 1'b1; c.kind = OK_STORE; c.step = -SLOT_BYTES; end
            UT_POP,  UT_RET:  begin c.upd = 1'b1; c.kind = OK_LOAD;  c.step = SLOT_BYTES;  end
            UT_SPADJ:         begin c.upd = 1'b1; c.kind = OK_NONE;  c.step = imm;         end
            UT_SPMEM:         c.kind = OK_SPMEM;
            UT_SPUSE:         begin c.use_sp = 1'b1; c.kind = OK_SPUSE; end
            default:          c.kind = OK_PASS;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/stkeng_window.sv
module stkeng_window #(
    parameter int LANES      = 4,
    parameter int NUM_ADDERS = 3,
    parameter int LW         = 2,
    parameter int CW         = 2
) (
    input  logic [LW-1:0]            start,
    input  logic [LANES-1:0]         valid,
    input  logic [LANES-1:0]         upd,
    input  logic [LANES-1:0]         use_sp,
    output logic [LANES-1:0]         take,
    output logic [LANES-1:0][CW-1:0] ord,
    output logic                     use_hit,
    output logic [LW-1:0]            use_lane,
    output logic [CW-1:0]            use_ord,
    output logic                     more,
    output logic [LW-1:0]            next_start
);
    // Picks the run of lanes that fits this cycle's adder and sync budget.
    always_comb begin
        int  nu;
        logic stop;
        take       = '0;
        ord        = '0;
        use_hit    = 1'b0;
        use_lane   = '0;
        use_ord    = '0;
        more       = 1'b0;
        next_start = '0;
        nu         = 0;
        stop       = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (i >= int'(start) && valid[i] && !stop) begin
                if ((upd[i] && nu == NUM_ADDERS) || (use_sp[i] && use_hit)) begin
                    stop       = 1'b1;
                    more       = 1'b1;
                    next_start = LW'(i);
                end else begin
                    take[i] = 1'b1;
                    ord[i]  = CW'(nu);
                    if (use_sp[i]) begin
                        use_hit  = 1'b1;
                        use_lane = LW'(i);
                        use_ord  = CW'(nu);
                    end
                    if (upd[i]) nu = nu + 1;
                end
            end
        end
    end
endmodule

// File: rtl/stkeng_adders.sv
module stkeng_adders import stkeng_pkg::*; #(
    parameter int NUM_ADDERS = 3,
    parameter int CW         = 2
) (
    input  word_t                   base,
    input  word_t [NUM_ADDERS-1:0]  step,
    input  logic                    zero_en,
    input  logic [CW-1:0]           zero_at,
    output word_t [NUM_ADDERS:0]    raw,
    output word_t [NUM_ADDERS:0]    acc
);
    // raw[k]: value reaching adder k; acc[k]: same after an optional sync clear.
    always_comb begin
        raw    = '0;
        acc    = '0;
        raw[0] = base;
        acc[0] = (zero_en && zero_at == '0) ? '0 : base;
        for (int k = 0; k < NUM_ADDERS; k++) begin
            raw[k+1] = acc[k] + step[k];
            acc[k+1] = (zero_en && int'(zero_at) == k + 1) ? '0 : raw[k+1];
        end
    end
endmodule

// File: rtl/stkeng_lane_out.sv
module stkeng_lane_out import stkeng_pkg::*; (
    input  logic          take,
    input  out_kind_e     kind,
    input  word_t         imm,
    input  word_t         pre,
    input  word_t         post,
    output logic          o_valid,
    output logic [TW-1:0] o_kind,
    output word_t         o_imm,
    output word_t         o_ofs
);
    always_comb begin
        o_valid = take && (kind != OK_NONE);
        o_kind  = '0;
        o_imm   = '0;
        o_ofs   = '0;
        if (o_valid) begin
            o_kind = kind;
            o_imm  = imm;
            unique case (kind)
                OK_STORE:          o_ofs = post;
                OK_LOAD, OK_SPMEM: o_ofs = pre;
                default:           o_ofs = '0;
            endcase
        end
    end
endmodule

// File: rtl/stack_delta_engine.sv
module stack_delta_engine import stkeng_pkg::*; #(
    parameter  int LANES      = 4,
    parameter  int NUM_ADDERS = 3,
    localparam int LW         = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int CW         = $clog2(NUM_ADDERS + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [LANES-1:0]          in_valid,
    input  logic [LANES-1:0][TW-1:0]  in_type,
    input  logic [LANES-1:0][DW-1:0]  in_imm,
    output logic                      in_ready,
    output logic [LANES-1:0]          out_valid,
    output logic [LANES-1:0][TW-1:0]  out_kind,
    output logic [LANES-1:0][DW-1:0]  out_imm,
    output logic [LANES-1:0][DW-1:0]  out_ofs,
    output logic                      out_sync_valid,
    output logic [LW-1:0]             out_sync_lane,
    output logic [DW-1:0]             out_sync_amt
);
    word_t                   delta_q;
    logic [LW-1:0]           start_q;
    class_t                  cls [LANES];
    logic [LANES-1:0]        upd_v, use_v, take;
    logic [LANES-1:0][CW-1:0] ord;
    logic                    use_hit, more;
    logic [LW-1:0]           use_lane, next_start;
    logic [CW-1:0]           use_ord;
    word_t [NUM_ADDERS-1:0]  step;
    word_t [NUM_ADDERS:0]    raw, acc;
    word_t                   pre  [LANES];
    word_t                   post [LANES];

    for (genvar gi = 0; gi < LANES; gi++) begin : g_cls
        assign cls[gi]   = classify(uop_type_e'(in_type[gi]), in_imm[gi]);
        assign upd_v[gi] = cls[gi].upd;
        assign use_v[gi] = cls[gi].use_sp;
    end

    stkeng_window #(.LANES(LANES), .NUM_ADDERS(NUM_ADDERS), .LW(LW), .CW(CW)) u_window (
        .start(start_q), .valid(in_valid), .upd(upd_v), .use_sp(use_v),
        .take(take), .ord(ord), .use_hit(use_hit), .use_lane(use_lane),
        .use_ord(use_ord), .more(more), .next_start(next_start)
    );

    // Route the k-th absorbed update of the window to adder k.
    always_comb begin
        step = '0;
        for (int k = 0; k < NUM_ADDERS; k++)
            for (int i = 0; i < LANES; i++)
                if (take[i] && upd_v[i] && int'(ord[i]) == k) step[k] = cls[i].step;
    end

    stkeng_adders #(.NUM_ADDERS(NUM_ADDERS), .CW(CW)) u_adders (
        .base(delta_q), .step(step), .zero_en(use_hit), .zero_at(use_ord),
        .raw(raw), .acc(acc)
    );

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            pre[i]  = (use_hit && i > int'(use_lane)) ? acc[ord[i]] : raw[ord[i]];
            post[i] = (upd_v[i] && int'(ord[i]) < NUM_ADDERS) ? raw[int'(ord[i]) + 1] : '0;
        end
    end

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        stkeng_lane_out u_lane (
            .take(take[gi]), .kind(cls[gi].kind), .imm(in_imm[gi]),
            .pre(pre[gi]), .post(post[gi]),
            .o_valid(out_valid[gi]), .o_kind(out_kind[gi]),
            .o_imm(out_imm[gi]), .o_ofs(out_ofs[gi])
        );
    end

    assign out_sync_valid = use_hit && (raw[use_ord] != '0);
    assign out_sync_lane  = out_sync_valid ? use_lane : '0;
    assign out_sync_amt   = out_sync_valid ? raw[use_ord] : '0;
    assign in_ready       = !more;

    always_ff @(posedge clk) begin
        if (rst) begin
            delta_q <= '0;
            start_q <= '0;
        end else begin
            delta_q <= acc[NUM_ADDERS];
            start_q <= next_start;
        end
    end

    // ---------------- assertions ----------------
    logic [LANES-1:0] use_out;
    for (genvar gi = 0; gi < LANES; gi++) begin : g_chk
        assign use_out[gi] = out_valid[gi] && (out_kind[gi] == TW'(OK_SPUSE));

        a_r4_adjust_cleared: assert property (@(posedge clk) disable iff (rst)
            (in_valid[gi] && in_type[gi] == TW'(UT_SPADJ)) |-> !out_valid[gi]);
    end

    a_r8_adder_budget: assert property (@(posedge clk) disable iff (rst)
        $countones(take & upd_v) <= NUM_ADDERS);

    a_r8_resume_mid_group: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> (start_q != '0));

    a_r10_single_user: assert property (@(posedge clk) disable iff (rst)
        $onehot0(use_out));

    a_r9_sync_on_user: assert property (@(posedge clk) disable iff (rst)
        out_sync_valid |-> use_out[out_sync_lane]);

    a_r12_idle_keeps_delta: assert property (@(posedge clk) disable iff (rst)
        (in_valid == '0) |=> $stable(delta_q));
endmodule

// File: tb/stack_delta_engine_test.sv
module stack_delta_engine_test;
    import stkeng_pkg::*;

    localparam int L = 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [L-1:0]         in_valid = '0;
    logic [L-1:0][2:0]    in_type  = '0;
    logic [L-1:0][31:0]   in_imm   = '0;
    logic                 in_ready;
    logic [L-1:0]         out_valid;
    logic [L-1:0][2:0]    out_kind;
    logic [L-1:0][31:0]   out_imm, out_ofs;
    logic                 out_sync_valid;
    logic [1:0]           out_sync_lane;
    logic [31:0]          out_sync_amt;

    stack_delta_engine uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_type(in_type), .in_imm(in_imm),
        .in_ready(in_ready), .out_valid(out_valid), .out_kind(out_kind),
        .out_imm(out_imm), .out_ofs(out_ofs), .out_sync_valid(out_sync_valid),
        .out_sync_lane(out_sync_lane), .out_sync_amt(out_sync_amt)
    );

    always #2 clk = ~clk;

    int     n_chk = 0;
    int     n_err = 0;
    int     cyc   = 0;
    word_t  md    = '0;
    string  g_tag = "";
    logic [2:0]  g_ty  [L];
    word_t       g_imm [L];
    logic [L-1:0] g_vm;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 199000) begin
            n_err = n_err + 1;
            n_chk = n_chk + 1;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 199000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_err = n_err + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(logic v, logic [2:0] t);
        if (!v) return "R12";
        case (t)
            3'd0:       return "R6";
            3'd1, 3'd3: return "R2";
            3'd2, 3'd4: return "R3";
            3'd5:       return "R4";
            3'd6:       return "R5";
            default:    return "R9";
        endcase
    endfunction

    // Drives g_* as one group and checks every cycle until it is consumed.
    task automatic run_group();
        int st, cut, nu, nus, guard;
        bit done, isu, ev;
        logic [2:0] ek;
        word_t ei, eo, esa;
        bit esv;
        logic [1:0] esl;
        logic [71:0] a, e;
        string tg;
        st = 0; done = 0; guard = 0;
        @(negedge clk);
        in_valid = g_vm;
        for (int i = 0; i < L; i++) begin
            in_type[i] = g_ty[i];
            in_imm[i]  = g_imm[i];
        end
        while (!done && guard < 8) begin
            guard = guard + 1;
            #1;
            cut = L; nu = 0; nus = 0;
            for (int i = st; i < L; i++) begin
                if (g_vm[i]) begin
                    isu = (g_ty[i] >= 3'd1 && g_ty[i] <= 3'd5);
                    if ((isu && nu == 3) || (g_ty[i] == 3'd7 && nus == 1)) begin
                        cut = i;
                        break;
                    end
                    if (isu) nu = nu + 1;
                    if (g_ty[i] == 3'd7) nus = nus + 1;
                end
            end
            esv = 0; esl = '0; esa = '0;
            for (int i = 0; i < L; i++) begin
                ev = 0; ek = '0; ei = '0; eo = '0;
                if (i >= st && i < cut && g_vm[i]) begin
                    case (g_ty[i])
                        3'd0: begin ev = 1; ek = 3'd1; ei = g_imm[i]; end
                        3'd1, 3'd3: begin md = md - 32'd4; ev = 1; ek = 3'd2; ei = g_imm[i]; eo = md; end
                        3'd2, 3'd4: begin ev = 1; ek = 3'd3; ei = g_imm[i]; eo = md; md = md + 32'd4; end
                        3'd5: md = md + g_imm[i];
                        3'd6: begin ev = 1; ek = 3'd4; ei = g_imm[i]; eo = md; end
                        default: begin
                            if (md != 0) begin esv = 1; esl = 2'(i); esa = md; end
                            md = '0; ev = 1; ek = 3'd5; ei = g_imm[i];
                        end
                    endcase
                end
                a = {4'b0, out_valid[i], out_kind[i], out_imm[i], out_ofs[i]};
                e = {4'b0, ev, ek, ei, eo};
                tg = (g_tag != "") ? g_tag : tag_of(g_vm[i], g_ty[i]);
                chk(a === e, tg, a, e);
            end
            a = {37'b0, out_sync_valid, out_sync_lane, out_sync_amt};
            e = {37'b0, esv, esl, esa};
            chk(a === e, (g_tag != "") ? g_tag : "R9", a, e);
            chk(in_ready === (cut == L), (g_tag != "") ? g_tag : "R8",
                72'(in_ready), 72'(cut == L));
            @(posedge clk);
            if (cut < L) begin
                st = cut;
                @(negedge clk);
            end else begin
                done = 1;
            end
        end
    endtask

    task automatic set_lane(input int l, input logic v, input logic [2:0] t, input word_t im);
        g_vm[l] = v; g_ty[l] = t; g_imm[l] = im;
    endtask

    initial begin
        g_vm = '0;
        for (int l = 0; l < L; l++) begin g_ty[l] = '0; g_imm[l] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state seen at the ports
        in_valid = 4'b0001; in_type[0] = 3'd6; in_imm[0] = 32'h55;
        #1;
        chk(in_ready === 1'b1, "R1", 72'(in_ready), 72'(1));
        chk(out_valid[0] === 1'b1 && out_ofs[0] === 32'd0, "R1",
            {39'b0, out_valid[0], out_ofs[0]}, {39'b0, 1'b1, 32'd0});
        @(posedge clk);

        // R8: four pushes need two cycles
        g_tag = "R8";
        for (int l = 0; l < L; l++) set_lane(l, 1, 3'd1, word_t'(l));
        run_group();

        // R7: in-order effects within one group
        g_tag = "R7";
        set_lane(0, 1, 3'd1, 32'h10); set_lane(1, 1, 3'd3, 32'h20);
        set_lane(2, 1, 3'd6, 32'h30); set_lane(3, 1, 3'd2, 32'h40);
        run_group();

        // R11: wrap below zero and back
        g_tag = "R11";
        set_lane(0, 1, 3'd5, 32'd0 - md - 32'd2); set_lane(1, 1, 3'd2, 32'h0);
        set_lane(2, 1, 3'd6, 32'h7);              set_lane(3, 1, 3'd0, 32'h8);
        run_group();

        // R10: two explicit users in one group
        g_tag = "R10";
        set_lane(0, 1, 3'd7, 32'h1); set_lane(1, 1, 3'd6, 32'h2);
        set_lane(2, 1, 3'd7, 32'h3); set_lane(3, 1, 3'd2, 32'h4);
        run_group();

        // Sweep: every type combination, all valid and then a rotating mask
        g_tag = "";
        for (int pass = 0; pass < 2; pass++) begin
            for (int g = 0; g < 4096; g++) begin
                for (int l = 0; l < L; l++) begin
                    g_ty[l]  = 3'((g >> (3 * l)) & 7);
                    g_imm[l] = word_t'(g) * 32'h9E3779B1 + word_t'(l) * 32'h01000193;
                end
                g_vm = (pass == 0) ? 4'hF : 4'(g ^ (g >> 5));
                run_group();
            end
        end

        @(negedge clk);
        in_valid = '0;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule